// File: doc/BRIEF.md
# Cache Replacement Victim Selector

This block picks which way of a set-associative cache is evicted when a lookup misses. It serves one set per cycle and holds a small replacement record for every set. Hits refresh that record. A miss reads it to name a victim, and the same miss refreshes it as if the victim had just been refilled. The cache around the block owns tags, data and refill; the block sees only the set index, the hit way, the two strobes and a per-way valid vector.

A parameter fixes the replacement policy when the block is built: `POL_LRU` is true LRU at 2 ways and a binary-tree pseudo-LRU at 4 or 8 ways, `POL_FIFO` is a round-robin pointer, `POL_NMRU` is the round-robin pointer that steps over the most recently used way, and `POL_RANDOM` draws from a free-running LFSR. Each cycle is decoded into one of three access kinds: `ACC_IDLE` (no strobe), `ACC_HIT` (hit strobe only) and `ACC_FILL` (miss strobe, with or without hit strobe). `ACC_IDLE` changes no record. `ACC_HIT` updates recency. `ACC_FILL` produces a victim and updates the record. Kinds follow the strobes cycle by cycle with no held state. The victim is combinational in the miss cycle, and record updates land on the next rising clock edge.

Top module: `repl_victim_sel`

## Requirements
- R1: `victim_valid` is 1 exactly in cycles with `miss_strobe` high. In every other cycle, including hit-only cycles, `victim_valid` is 0 and `victim_way` is 0. A hit never produces a victim.
- R2: On a miss, if `way_valid` (bit i describes way i) has any zero bit, the victim is the lowest-numbered way whose bit is 0, whatever the policy.
- R3: `POL_LRU` with 2 ways keeps one bit per set, and the victim is the way not accessed most recently. Hits and fills both count as accesses.
- R4: `POL_LRU` with 4 or 8 ways keeps WAYS-1 tree bits per set. An access sets every node on its path to point away from the accessed way. The victim is found by walking from the root, where a node bit of 0 selects the lower-numbered half.
- R5: `POL_FIFO` names the set's pointer as victim. The pointer moves to victim+1 (wrapping to 0) after each miss decided by the policy. Hits, and misses resolved through R2, leave it unchanged.
- R6: `POL_NMRU` names the pointer unless it equals the set's most recently used way, and in that case it names the next way (wrapping). After such a miss the pointer becomes victim+1. Hits and fills both record the most recently used way.
- R7: `POL_RANDOM` takes the victim from the low log2(WAYS) bits of a free-running LFSR. The result ignores access history, is always a legal way index, and varies over successive misses.
- R8: When `hit_strobe` and `miss_strobe` are both high, the miss wins. The victim is produced and the record is updated for the filled victim, and the hit is ignored.
- R9: Each set's record is independent: activity in one set does not change the victim chosen in another.
- R10: Reset clears every record to zero, so pointers and most-recent fields start at way 0 and trees point to way 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| set_idx | input | log2(SETS) | Set addressed this cycle |
| hit_strobe | input | 1 | Lookup hit in `hit_way` |
| hit_way | input | log2(WAYS) | Way that hit, binary |
| miss_strobe | input | 1 | Lookup missed; a victim is requested |
| way_valid | input | WAYS | Bit i is 1 when way i of the set holds a line |
| victim_way | output | log2(WAYS) | Way to evict, binary; 0 when no miss |
| victim_valid | output | 1 | Victim is being presented this cycle |

## Verification
A refresh by a hit and a victim choice by a miss can fall in the same cycle, because the two strobes are independent inputs. The bench raises both strobes on a fresh set with the hit naming a different way. It checks that the victim equals the one a fresh set yields. It then issues a plain miss to the same set and checks that the second victim follows from a refill of the first victim, not from the hit, under every policy. A hit directly followed by a miss to the same set is also checked against recency: the just-hit way must be spared.

// File: rtl/repl_pkg.sv
`timescale 1ns/1ps
package repl_pkg;

    typedef enum logic [1:0] {
        POL_RANDOM = 2'd0,
        POL_LRU    = 2'd1,
        POL_FIFO   = 2'd2,
        POL_NMRU   = 2'd3
    } repl_policy_e;

    typedef enum logic [1:0] {
        ACC_IDLE = 2'd0,
        ACC_HIT  = 2'd1,
        ACC_FILL = 2'd2
    } acc_kind_e;

endpackage

// File: rtl/repl_lfsr.sv
`timescale 1ns/1ps
// Free-running Fibonacci XNOR shift register; the all-zero reset state is legal.
module repl_lfsr #(
    parameter int          W        = 16,
    parameter logic [W-1:0] TAP_MASK = 16'hD008
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] q
);
    logic fb;

    assign fb = ~^(q & TAP_MASK);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= {q[W-2:0], fb};
        end
    end
endmodule

// File: rtl/repl_first_free.sv
`timescale 1ns/1ps
// Lowest-numbered way whose valid bit is clear.
module repl_first_free #(
    parameter  int WAYS  = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]  way_valid,
    output logic             found,
    output logic [WAY_W-1:0] way
);
    always_comb begin
        found = 1'b0;
        way   = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!way_valid[i]) begin
                found = 1'b1;
                way   = WAY_W'(i);
            end
        end
    end
endmodule

// File: rtl/repl_plru_tree.sv
`timescale 1ns/1ps
// Binary-tree recency logic. Node n (1-based heap order) is stored at
// tree_q[n-1]; a node bit of 0 points the victim walk to the lower half.
module repl_plru_tree #(
    parameter  int WAYS  = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-2:0]  tree_q,
    input  logic [WAY_W-1:0] acc_way,
    output logic [WAYS-2:0]  tree_d,
    output logic [WAY_W-1:0] victim
);
    logic [2*WAYS-1:0] pad_q;
    logic [2*WAYS-1:0] pad_d;
    logic [WAY_W:0]    walk;
    logic [WAY_W:0]    node;
    logic [WAY_W:0]    child;
    logic              unused_pad;

    assign pad_q = {{WAYS{1'b0}}, tree_q, 1'b0};

    // Victim walk from the root.
    always_comb begin
        walk = (WAY_W+1)'(1);
        for (int l = 0; l < WAY_W; l++) begin
            walk = {walk[WAY_W-1:0], pad_q[walk]};
        end
        victim = walk[WAY_W-1:0];
    end

    // Path update: each node on the access path points away from it.
    always_comb begin
        pad_d = pad_q;
        node  = '0;
        child = '0;
        for (int l = 0; l < WAY_W; l++) begin
            node        = {1'b1, acc_way} >> (WAY_W - l);
            child       = {1'b1, acc_way} >> (WAY_W - l - 1);
            pad_d[node] = ~child[0];
        end
    end

    assign tree_d     = pad_d[WAYS-1:1];
    assign unused_pad = ^{pad_d[2*WAYS-1:WAYS], pad_d[0]};
endmodule

// File: rtl/repl_victim_sel.sv
`timescale 1ns/1ps
module repl_victim_sel #(
    parameter  int                     WAYS   = 4,
    parameter  int                     SETS   = 16,
    parameter  repl_pkg::repl_policy_e POLICY = repl_pkg::POL_LRU,
    localparam int                     WAY_W  = $clog2(WAYS),
    localparam int                     SET_W  = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] set_idx,
    input  logic             hit_strobe,
    input  logic [WAY_W-1:0] hit_way,
    input  logic             miss_strobe,
    input  logic [WAYS-1:0]  way_valid,
    output logic [WAY_W-1:0] victim_way,
    output logic             victim_valid
);
    import repl_pkg::*;

    localparam int TREE_W = WAYS - 1;

    acc_kind_e        acc_kind;
    logic [WAY_W-1:0] acc_way;
    logic [WAY_W-1:0] policy_way;
    logic [WAY_W-1:0] free_way;
    logic             free_found;
    logic             policy_fill;

    // Access decode: a miss outranks a hit in the same cycle.
    always_comb begin
        if (miss_strobe) begin
            acc_kind = ACC_FILL;
        end else if (hit_strobe) begin
            acc_kind = ACC_HIT;
        end else begin
            acc_kind = ACC_IDLE;
        end
    end

    repl_first_free #(.WAYS(WAYS)) u_first_free (
        .way_valid (way_valid),
        .found     (free_found),
        .way       (free_way)
    );

    // Output process.
    always_comb begin
        unique case (acc_kind)
            ACC_FILL: begin
                victim_valid = 1'b1;
                victim_way   = free_found ? free_way : policy_way;
                acc_way      = victim_way;
            end
            ACC_HIT: begin
                victim_valid = 1'b0;
                victim_way   = '0;
                acc_way      = hit_way;
            end
            default: begin
                victim_valid = 1'b0;
                victim_way   = '0;
                acc_way      = hit_way;
            end
        endcase
    end

    assign policy_fill = (acc_kind == ACC_FILL) && !free_found;

    generate
        if (POLICY == POL_LRU) begin : g_lru
            logic [TREE_W-1:0] tree_q [SETS];
            logic [TREE_W-1:0] tree_d;
            logic              unused_lru;

            repl_plru_tree #(.WAYS(WAYS)) u_tree (
                .tree_q  (tree_q[set_idx]),
                .acc_way (acc_way),
                .tree_d  (tree_d),
                .victim  (policy_way)
            );

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
                end else if (acc_kind != ACC_IDLE) begin
                    tree_q[set_idx] <= tree_d;
                end
            end
            assign unused_lru = policy_fill;
        end else if (POLICY == POL_FIFO || POLICY == POL_NMRU) begin : g_ring
            logic [WAY_W-1:0] ptr_q [SETS];
            logic [WAY_W-1:0] ptr_cur;

            assign ptr_cur = ptr_q[set_idx];

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
                end else if (policy_fill) begin
                    ptr_q[set_idx] <= policy_way + 1'b1;
                end
            end

            if (POLICY == POL_NMRU) begin : g_nmru
                logic [WAY_W-1:0] mru_q [SETS];

                assign policy_way = (ptr_cur == mru_q[set_idx]) ? ptr_cur + 1'b1 : ptr_cur;

                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        for (int s = 0; s < SETS; s++) mru_q[s] <= '0;
                    end else if (acc_kind != ACC_IDLE) begin
                        mru_q[set_idx] <= acc_way;
                    end
                end
            end else begin : g_fifo
                logic unused_fifo;
                assign policy_way  = ptr_cur;
                assign unused_fifo = ^acc_way;
            end
        end else begin : g_random
            localparam int LFSR_W = 16;
            logic [LFSR_W-1:0] lfsr_q;
            logic              unused_rand;

            repl_lfsr #(.W(LFSR_W)) u_lfsr (
                .clk   (clk),
                .rst_n (rst_n),
                .q     (lfsr_q)
            );

            assign policy_way  = lfsr_q[WAY_W-1:0];
            assign unused_rand = ^{lfsr_q[LFSR_W-1:WAY_W], set_idx, acc_way, policy_fill};
        end
    endgenerate
endmodule

module repl_victim_chk #(
    parameter  int                     WAYS   = 4,
    parameter  int                     SETS   = 16,
    parameter  repl_pkg::repl_policy_e POLICY = repl_pkg::POL_LRU,
    localparam int                     WAY_W  = $clog2(WAYS),
    localparam int                     SET_W  = $clog2(SETS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [SET_W-1:0] set_idx,
    input logic             hit_strobe,
    input logic [WAY_W-1:0] hit_way,
    input logic             miss_strobe,
    input logic [WAYS-1:0]  way_valid,
    input logic [WAY_W-1:0] victim_way,
    input logic             victim_valid
);
    import repl_pkg::*;

    logic            past_ok;
    logic [WAYS-1:0] below_mask;

    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assign below_mask = (WAYS'(1) << victim_way) - WAYS'(1);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !miss_strobe |-> (!victim_valid && victim_way == '0));

    // R1
    miss_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss_strobe |-> victim_valid);

    // R2
    free_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_strobe && !(&way_valid)) |->
            (!way_valid[victim_way] && ((way_valid & below_mask) == below_mask)));

    generate
        if (POLICY == POL_LRU || POLICY == POL_NMRU) begin : g_recent
            // R3 R4 R6
            recent_spared_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (past_ok && miss_strobe && (&way_valid) &&
                 $past(hit_strobe && !miss_strobe) && set_idx == $past(set_idx))
                |-> victim_way != $past(hit_way));
        end
        if (POLICY == POL_FIFO || POLICY == POL_NMRU) begin : g_rotate
            // R5 R6
            rotate_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (past_ok && miss_strobe && (&way_valid) &&
                 $past(miss_strobe && (&way_valid)) && set_idx == $past(set_idx))
                |-> victim_way == WAY_W'($past(victim_way) + 1'b1));
        end
    endgenerate
endmodule

bind repl_victim_sel repl_victim_chk #(
    .WAYS   (WAYS),
    .SETS   (SETS),
    .POLICY (POLICY)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .set_idx      (set_idx),
    .hit_strobe   (hit_strobe),
    .hit_way      (hit_way),
    .miss_strobe  (miss_strobe),
    .way_valid    (way_valid),
    .victim_way   (victim_way),
    .victim_valid (victim_valid)
);

// File: tb/repl_victim_sel_bench.sv
`timescale 1ns/1ps
module repl_victim_sel_bench;
    import repl_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] set_i = '0;
    logic       hit_s = 1'b0;
    logic [2:0] hw = '0;
    logic       miss_s = 1'b0;
    logic [7:0] vld = '1;
    logic       done = 1'b0;

    logic [1:0] v_p4, v_ff, v_nm, v_rd;
    logic [0:0] v_l2;
    logic [2:0] v_p8;
    logic       vv_p4, vv_l2, vv_p8, vv_ff, vv_nm, vv_rd;

    int n_chk  = 0;
    int n_fail = 0;
    int r_p4, r_l2, r_p8, r_ff, r_nm, r_rd, r_vv;

    always #10 clk = ~clk;

    repl_victim_sel #(.WAYS(4), .SETS(16), .POLICY(POL_LRU)) u_repl_victim_sel (
        .clk(clk), .rst_n(rst_n), .set_idx(set_i), .hit_strobe(hit_s), .hit_way(hw[1:0]),
        .miss_strobe(miss_s), .way_valid(vld[3:0]), .victim_way(v_p4), .victim_valid(vv_p4));
    repl_victim_sel #(.WAYS(2), .SETS(16), .POLICY(POL_LRU)) u_repl_victim_sel_l2 (
        .clk(clk), .rst_n(rst_n), .set_idx(set_i), .hit_strobe(hit_s), .hit_way(hw[0:0]),
        .miss_strobe(miss_s), .way_valid(vld[1:0]), .victim_way(v_l2), .victim_valid(vv_l2));
    repl_victim_sel #(.WAYS(8), .SETS(16), .POLICY(POL_LRU)) u_repl_victim_sel_p8 (
        .clk(clk), .rst_n(rst_n), .set_idx(set_i), .hit_strobe(hit_s), .hit_way(hw),
        .miss_strobe(miss_s), .way_valid(vld), .victim_way(v_p8), .victim_valid(vv_p8));
    repl_victim_sel #(.WAYS(4), .SETS(16), .POLICY(POL_FIFO)) u_repl_victim_sel_ff (
        .clk(clk), .rst_n(rst_n), .set_idx(set_i), .hit_strobe(hit_s), .hit_way(hw[1:0]),
        .miss_strobe(miss_s), .way_valid(vld[3:0]), .victim_way(v_ff), .victim_valid(vv_ff));
    repl_victim_sel #(.WAYS(4), .SETS(16), .POLICY(POL_NMRU)) u_repl_victim_sel_nm (
        .clk(clk), .rst_n(rst_n), .set_idx(set_i), .hit_strobe(hit_s), .hit_way(hw[1:0]),
        .miss_strobe(miss_s), .way_valid(vld[3:0]), .victim_way(v_nm), .victim_valid(vv_nm));
    repl_victim_sel #(.WAYS(4), .SETS(16), .POLICY(POL_RANDOM)) u_repl_victim_sel_rd (
        .clk(clk), .rst_n(rst_n), .set_idx(set_i), .hit_strobe(hit_s), .hit_way(hw[1:0]),
        .miss_strobe(miss_s), .way_valid(vld[3:0]), .victim_way(v_rd), .victim_valid(vv_rd));

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic sample();
        r_p4 = int'(v_p4); r_l2 = int'(v_l2); r_p8 = int'(v_p8);
        r_ff = int'(v_ff); r_nm = int'(v_nm); r_rd = int'(v_rd);
        r_vv = int'(vv_p4 & vv_l2 & vv_p8 & vv_ff & vv_nm & vv_rd);
        if (!miss_s) r_vv = int'(vv_p4 | vv_l2 | vv_p8 | vv_ff | vv_nm | vv_rd);
    endtask

    // Drive one cycle at the falling edge, sample mid-cycle, release after the rising edge.
    task automatic cycle(input logic [3:0] s, input logic h, input logic [2:0] w,
                         input logic m, input logic [7:0] vl);
        @(negedge clk);
        set_i = s; hit_s = h; hw = w; miss_s = m; vld = vl;
        #2;
        sample();
        @(posedge clk);
        #1;
        hit_s = 1'b0; miss_s = 1'b0; vld = '1;
    endtask

    task automatic expect_all(input string tag, input int p4, input int l2, input int p8,
                              input int ff, input int nm);
        check({tag, " R4 plru4"}, r_p4, p4);
        check({tag, " R3 lru2"},  r_l2, l2);
        check({tag, " R4 plru8"}, r_p8, p8);
        check({tag, " R5 fifo"},  r_ff, ff);
        check({tag, " R6 nmru"},  r_nm, nm);
    endtask

    task automatic t_reset_idle();
        @(negedge clk); #2;
        sample();
        check("R10 R1 idle valid after reset", r_vv, 0);
        check("R1 idle victim way", r_p4 + r_l2 + r_p8 + r_ff + r_nm + r_rd, 0);
        cycle(4'd7, 1'b1, 3'd2, 1'b0, 8'hFF);
        check("R1 hit-only gives no victim", r_vv, 0);
        check("R1 hit-only victim way zero", r_p4 + r_p8 + r_ff + r_nm, 0);
    endtask

    task automatic t_plain_rotation();
        int e_p4[4] = '{0, 2, 1, 3};
        int e_l2[4] = '{0, 1, 0, 1};
        int e_p8[4] = '{0, 4, 2, 6};
        int e_ff[4] = '{0, 1, 2, 3};
        int e_nm[4] = '{1, 2, 3, 0};
        for (int i = 0; i < 4; i++) begin
            cycle(4'd0, 1'b0, 3'd0, 1'b1, 8'hFF);
            check("R1 miss valid", r_vv, 1);
            expect_all((i == 0) ? "R10 first miss" : "rotation", e_p4[i], e_l2[i], e_p8[i], e_ff[i], e_nm[i]);
            check("R7 random in range", int'(r_rd < 4), 1);
        end
    endtask

    task automatic t_hit_touch();
        cycle(4'd1, 1'b1, 3'd1, 1'b0, 8'hFF);
        cycle(4'd1, 1'b0, 3'd0, 1'b1, 8'hFF);
        expect_all("hit then miss", 2, 0, 4, 0, 0);
    endtask

    task automatic t_free_fill();
        cycle(4'd2, 1'b0, 3'd0, 1'b1, 8'hFB);
        expect_all("R2 one hole", 2, 0, 2, 2, 2);
        check("R2 random overridden", r_rd, 2);
        cycle(4'd2, 1'b0, 3'd0, 1'b1, 8'hFF);
        expect_all("R2 after hole fill", 0, 1, 4, 0, 0);
        cycle(4'd3, 1'b0, 3'd0, 1'b1, 8'hF5);
        expect_all("R2 lowest of holes", 1, 1, 1, 1, 1);
        check("R2 random lowest hole", r_rd, 1);
    endtask

    task automatic t_collision();
        cycle(4'd4, 1'b1, 3'd3, 1'b1, 8'hFF);
        check("R8 both strobes valid", r_vv, 1);
        expect_all("R8 both strobes", 0, 0, 0, 0, 1);
        cycle(4'd4, 1'b0, 3'd0, 1'b1, 8'hFF);
        expect_all("R8 fill recorded not hit", 2, 1, 4, 1, 2);
    endtask

    task automatic t_isolation();
        cycle(4'd5, 1'b0, 3'd0, 1'b1, 8'hFF);
        expect_all("R9 untouched set", 0, 0, 0, 0, 1);
    endtask

    task automatic t_random();
        bit [3:0] seen = '0;
        int       kinds = 0;
        for (int i = 0; i < 40; i++) begin
            cycle(4'd6, (i % 3) == 0, 3'(i), 1'b1, 8'hFF);
            check("R7 random legal way", int'(r_rd < 4), 1);
            if (r_rd < 4) seen[r_rd] = 1'b1;
        end
        for (int k = 0; k < 4; k++) kinds += int'(seen[k]);
        check("R7 random varies", int'(kinds >= 2), 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset_idle();
        t_plain_rotation();
        t_hit_touch();
        t_free_fill();
        t_collision();
        t_isolation();
        t_random();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule